// File: doc/BRIEF.md
# Weighted Multithreaded Issue Scheduler

This block picks, on each clock cycle, the one hardware thread context that may send an instruction into a shared execution pipeline. Each context raises a ready flag when it can issue and drops the flag while it is stalled, for example while it waits for a cache line refill. Stalled contexts are skipped within the same cycle, so an issue slot goes unused only when no context can use it. Switching from one context to another costs no cycles.

Cycle sharing is proportional. Each context has a programmable weight and a credit counter. A grant consumes one credit. When every ready context with a nonzero weight has run out of credit, all counters reload from their weights. Among the contexts that still hold credit, the choice is round-robin, starting after the last context granted. After reset every weight is 1, so ready contexts share issue cycles evenly.

A context can request exclusive issue, which turns multithreading off so that it can run a critical section. While it holds that request, only it may issue. If it stalls, the cycle goes unused and no other thread takes it.

Top module: `issue_sched`

## Requirements
- R1: `grant` has at most one bit set, and `valid` is high exactly when `grant` is nonzero.
- R2: A context whose `ready` bit is low is never granted. With no lock active, `valid` is high in every cycle in which at least one context is ready.
- R3: After reset all weights are 1. With every context ready, grants rotate through the contexts in ascending index order starting at context 0 and wrap after the highest index. A stalled context is left out of the rotation and costs no cycle.
- R4: Weight register k (k = `wr_idx`) is loaded from `wr_val` on a clock edge with `wr_en` high. Once the credits have reloaded, each ready context with weight w receives exactly w grants per reload round. With weights 3 and 1 on contexts 0 and 1, 40 cycles give 30 grants to context 0 and 10 to context 1.
- R5: A context with weight 0 is never granted while a ready context with a nonzero weight exists. When only zero-weight contexts are ready, they are still granted.
- R6: `lock_req[k]` high starts a lock owned by the lowest-index requester. While the owner holds its request, only the owner may be granted and requests from other contexts are ignored. When the owner drops its request, the lock is released, and any remaining requester takes over the lock.
- R7: While locked, a stall of the owner leaves `valid` low. The grant does not move to another context.
- R8: `valid` is low in every cycle in which no context is ready.
- R9: During and right after reset, `grant` is 0 and `valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ready | input | N_CTX | Per-context ready flag, low while stalled |
| lock_req | input | N_CTX | Per-context request for exclusive issue |
| wr_en | input | 1 | Weight write strobe |
| wr_idx | input | IW | Index of the context whose weight is written |
| wr_val | input | WW | New weight value |
| grant | output | N_CTX | One-hot issue grant for the current cycle |
| valid | output | 1 | A context is granted this cycle |

## Verification
Assertions check the cycle-level rules on every cycle: the grant is one-hot, it never goes to a stalled context, the slot is not wasted while some context is ready, the grant stays with the owner during a lock, and a zero-weight context is not granted while a weighted context is ready. Only the bench scenarios can show the properties that depend on a sequence of cycles. These are the exact rotation order after reset, the skip pattern when one context stalls, the 3:1 grant counts over whole reload rounds, and the owner handover when a lock is released.

// File: rtl/issue_sched_pkg.sv
package issue_sched_pkg;
   // Index width that stays at least one bit for a single context
   function automatic int unsigned idx_w(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/sched_rr_pick.sv
module sched_rr_pick #(
   parameter int unsigned N  = 4,
   parameter int unsigned IW = 2
) (
   input  logic [N-1:0]  cand,
   input  logic [IW-1:0] last,
   output logic [N-1:0]  gnt
);
   always_comb begin
      logic found;
      gnt   = '0;
      found = 1'b0;
      for (int off = 1; off <= int'(N); off++) begin
         if (!found && cand[IW'((int'(last) + off) % int'(N))]) begin
            gnt[IW'((int'(last) + off) % int'(N))] = 1'b1;
            found = 1'b1;
         end
      end
   end
endmodule

// File: rtl/sched_credit_bank.sv
module sched_credit_bank #(
   parameter int unsigned N  = 4,
   parameter int unsigned WW = 4,
   parameter int unsigned IW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [IW-1:0] wr_idx,
   input  logic [WW-1:0] wr_val,
   input  logic [N-1:0]  ready,
   input  logic [N-1:0]  grant,
   input  logic          hold,
   output logic [N-1:0]  elig,
   output logic [N-1:0]  wt_nz
);
   logic [N-1:0] cr_nz;
   logic         reload_now;

   // Reload once no ready weighted context holds credit
   assign reload_now = ~|(ready & wt_nz & cr_nz);

   for (genvar i = 0; i < int'(N); i++) begin : g_ctx
      logic [WW-1:0] wt_q, cr_q, eff_c;
      logic          dec;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                             wt_q <= WW'(1);
         else if (wr_en && wr_idx == IW'(i))     wt_q <= wr_val;
      end

      assign eff_c = reload_now ? wt_q : cr_q;
      assign dec   = grant[i] && (|eff_c);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     cr_q <= WW'(1);
         else if (!hold) cr_q <= eff_c - WW'(dec);
      end

      assign cr_nz[i] = |cr_q;
      assign wt_nz[i] = |wt_q;
      assign elig[i]  = ready[i] && wt_nz[i] && (|eff_c);
   end
endmodule

// File: rtl/sched_lock.sv
module sched_lock #(
   parameter int unsigned N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lock_req,
   output logic         lock_on,
   output logic [N-1:0] owner_oh
);
   logic         held_q;
   logic [N-1:0] owner_q;
   logic         keep;

   assign keep = held_q && (|(lock_req & owner_q));

   always_comb begin
      if (keep) begin
         lock_on  = 1'b1;
         owner_oh = owner_q;
      end else begin
         lock_on  = |lock_req;
         owner_oh = lock_req & (~lock_req + N'(1));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q  <= 1'b0;
         owner_q <= '0;
      end else begin
         held_q  <= lock_on;
         owner_q <= owner_oh;
      end
   end

   // R6: an owner that keeps requesting keeps the lock
   a_r6_owner_kept: assert property (@(posedge clk) disable iff (!rst_n)
      lock_on |=> (!(|(lock_req & $past(owner_oh))) || owner_oh == $past(owner_oh)));
endmodule

// File: rtl/issue_sched.sv
module issue_sched
   import issue_sched_pkg::*;
#(
   parameter int unsigned N_CTX = 4,
   parameter int unsigned WW    = 4,
   parameter int unsigned IW    = idx_w(N_CTX)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_CTX-1:0] ready,
   input  logic [N_CTX-1:0] lock_req,
   input  logic             wr_en,
   input  logic [IW-1:0]    wr_idx,
   input  logic [WW-1:0]    wr_val,
   output logic [N_CTX-1:0] grant,
   output logic             valid
);
   if (N_CTX < 1 || N_CTX > 9) begin : g_bad_n
      $error("issue_sched: N_CTX must lie in 1..9");
   end
   if (WW < 1) begin : g_bad_w
      $error("issue_sched: WW must be at least 1");
   end

   logic [N_CTX-1:0] elig, wt_nz, cand, pick, owner_oh;
   logic             lock_on;
   logic [IW-1:0]    last_q, gidx;

   sched_lock #(.N(N_CTX)) i_lock (
      .clk(clk), .rst_n(rst_n), .lock_req(lock_req),
      .lock_on(lock_on), .owner_oh(owner_oh)
   );

   sched_credit_bank #(.N(N_CTX), .WW(WW), .IW(IW)) i_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_val(wr_val), .ready(ready), .grant(grant), .hold(lock_on),
      .elig(elig), .wt_nz(wt_nz)
   );

   // Fall back to plain readiness when only zero-weight contexts are ready
   assign cand = (|elig) ? elig : ready;

   sched_rr_pick #(.N(N_CTX), .IW(IW)) i_pick (
      .cand(cand), .last(last_q), .gnt(pick)
   );

   assign grant = lock_on ? (owner_oh & ready) : pick;
   assign valid = |grant;

   always_comb begin
      gidx = '0;
      for (int k = 0; k < int'(N_CTX); k++)
         if (grant[k]) gidx = IW'(k);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                last_q <= IW'(N_CTX - 1);
      else if (valid && !lock_on) last_q <= gidx;
   end

   // R1
   a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant) && (valid == (grant != '0)));
   // R2
   a_r2_no_stalled: assert property (@(posedge clk) disable iff (!rst_n)
      (grant & ~ready) == '0);
   a_r2_no_waste: assert property (@(posedge clk) disable iff (!rst_n)
      (!lock_on && ready != '0) |-> valid);
   // R5
   a_r5_zero_weight: assert property (@(posedge clk) disable iff (!rst_n)
      (!lock_on && (|(grant & ~wt_nz))) |-> !(|(ready & wt_nz)));
   // R6, R7
   a_r6_lock_pinned: assert property (@(posedge clk) disable iff (!rst_n)
      lock_on |-> (grant & ~owner_oh) == '0);
   // R8
   a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (ready == '0) |-> !valid);
endmodule

// File: tb/test_issue_sched.sv
module test_issue_sched;
   localparam int N = 4;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] ready = '0, lock_req = '0;
   logic         wr_en = 1'b0;
   logic [1:0]   wr_idx = '0;
   logic [3:0]   wr_val = '0;
   logic [N-1:0] grant;
   logic         valid;

   typedef struct { logic [N-1:0] allow; logic vld; int req; } exp_t;
   exp_t q[$];
   int n_chk = 0, n_fail = 0;
   int gcnt[N];
   bit done = 0;

   always #10 clk = ~clk;

   issue_sched #(.N_CTX(N), .WW(4)) i_issue_sched (
      .clk(clk), .rst_n(rst_n), .ready(ready), .lock_req(lock_req),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val),
      .grant(grant), .valid(valid)
   );

   task automatic check(input bit ok, input int req, input string what);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL R%0d %s", req, what);
      end
   endtask

   // Driver: one cycle of stimulus plus its expected item
   task automatic step(input logic [N-1:0] r, input logic [N-1:0] l,
                       input logic [N-1:0] allow, input logic vld, input int req);
      exp_t e;
      @(posedge clk); #2;
      ready = r; lock_req = l; wr_en = 1'b0;
      e.allow = allow; e.vld = vld; e.req = req;
      q.push_back(e);
   endtask

   task automatic wr_weight(input int idx, input int val);
      exp_t e;
      @(posedge clk); #2;
      ready = '0; lock_req = '0;
      wr_en = 1'b1; wr_idx = 2'(idx); wr_val = 4'(val);
      e.allow = '0; e.vld = 1'b0; e.req = 8;   // R8: idle while writing
      q.push_back(e);
   endtask

   task automatic settle();
      @(negedge clk); #1;
   endtask

   // Monitor
   always @(negedge clk) begin
      if (rst_n) for (int k = 0; k < N; k++) if (grant[k]) gcnt[k]++;
      if (q.size() != 0) begin
         exp_t e;
         bit ok;
         e  = q.pop_front();
         ok = (valid == e.vld) && ((grant & ~e.allow) == '0) && $onehot0(grant)
              && (valid == (grant != '0));
         check(ok, e.req, $sformatf("grant=%b valid=%b expected allow=%b valid=%b",
                                    grant, valid, e.allow, e.vld));
      end
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      for (int k = 0; k < N; k++) gcnt[k] = 0;
      #35;
      // R9: reset state
      check(grant == '0 && valid == 1'b0, 9,
            $sformatf("grant=%b valid=%b expected 0000/0", grant, valid));
      @(posedge clk); #2; rst_n = 1'b1;
      settle();
      check(grant == '0 && valid == 1'b0, 9,
            $sformatf("grant=%b valid=%b expected 0000/0", grant, valid));

      // R3: strict rotation from context 0
      for (int c = 0; c < 8; c++) step('1, '0, 4'(1 << (c % 4)), 1'b1, 3);
      // R3/R2: context 2 stalled, skipped without a lost cycle
      for (int c = 0; c < 6; c++) begin
         logic [N-1:0] a;
         a = (c % 3 == 0) ? 4'b0001 : (c % 3 == 1) ? 4'b0010 : 4'b1000;
         step(4'b1011, '0, a, 1'b1, 3);
      end
      // R8: nothing ready
      for (int c = 0; c < 3; c++) step('0, '0, '0, 1'b0, 8);

      // R4: weights 3,1,0,0
      wr_weight(0, 3); wr_weight(1, 1); wr_weight(2, 0); wr_weight(3, 0);
      step('0, '0, '0, 1'b0, 8);
      settle();
      for (int k = 0; k < N; k++) gcnt[k] = 0;
      for (int c = 0; c < 40; c++) step(4'b0011, '0, 4'b0011, 1'b1, 4);
      settle();
      check(gcnt[0] == 30, 4, $sformatf("ctx0 grants=%0d expected 30", gcnt[0]));
      check(gcnt[1] == 10, 4, $sformatf("ctx1 grants=%0d expected 10", gcnt[1]));

      // R5: zero-weight contexts excluded, then granted when alone
      for (int c = 0; c < 10; c++) step('1, '0, 4'b0011, 1'b1, 5);
      for (int c = 0; c < 4; c++)  step(4'b1100, '0, 4'b1100, 1'b1, 5);
      settle();
      check(gcnt[2] + gcnt[3] == 4, 5,
            $sformatf("zero-weight grants=%0d expected 4", gcnt[2] + gcnt[3]));

      // restore equal weights
      for (int k = 0; k < N; k++) wr_weight(k, 1);

      // R6: lock by context 2, later request from 0 ignored
      for (int c = 0; c < 4; c++) step('1, 4'b0100, 4'b0100, 1'b1, 6);
      for (int c = 0; c < 3; c++) step('1, 4'b0101, 4'b0100, 1'b1, 6);
      // R7: owner stalls -> no grant
      for (int c = 0; c < 3; c++) step(4'b1011, 4'b0101, '0, 1'b0, 7);
      // R6: owner releases, waiting requester 0 takes over
      for (int c = 0; c < 3; c++) step('1, 4'b0001, 4'b0001, 1'b1, 6);
      // release all: normal sharing resumes
      for (int c = 0; c < 4; c++) step('1, '0, '1, 1'b1, 2);
      settle();
      settle();

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule